// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds operands one bit per clock, least significant bit first. It uses two serial shift registers and a single full adder. The carry of the full adder is held in a flip-flop between bits. The operand register takes new bits on a serial input at its top end while its bottom bit feeds the adder. The accumulator register takes each sum bit back in at its top end, so after one pass of `WIDTH` clocks it holds the new total.

Operands arrive in passes of `WIDTH` clocks. During each pass the operand shifted in on the previous pass is added to the accumulator, and at the same time the next operand is shifted in. A `done_o` pulse marks the end of each pass. A final carry is dropped, so the result is modulo 2^WIDTH, and `ovf_o` reports that carry. A synchronous clear empties both registers, the carry, the pass counter and the flags.

Top module: `serial_accum_adder`

## Requirements
- R1: After asynchronous reset (`rst_ni` low), `sum_o` is 0 and `done_o` and `ovf_o` are 0.
- R2: During a pass, the bits on `bit_i` are taken least significant bit first, one on each clock with `run_i` high. The operand they form is the addend used by the next pass.
- R3: At the end of a pass, `sum_o` equals the value it held before the pass plus the previous pass's operand, modulo 2^WIDTH.
- R4: `done_o` is high for exactly one cycle, in the cycle after the clock that consumed the WIDTH-th bit of a pass. It is low at all other times.
- R5: At the end of each pass, `ovf_o` becomes the carry out of the top bit. It keeps that value until the next pass ends or a clear occurs.
- R6: The carry is zero at the start of every pass, so a carry out of one pass does not change the next sum.
- R7: A cycle with `run_i` low changes neither the registers nor the bit position within the pass, so a pass may be stalled mid-way and then resumed.
- R8: `clear_i` high on a clock zeroes both registers, the carry, the bit position, `done_o` and `ovf_o`. It wins over `run_i` in the same cycle.
- R9: `sum_o` shows the accumulator as it shifts. With WIDTH=4, adding 0011 to 0111 gives 0011, 1001, 0100, 1010 after bits one to four.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear, wins over run_i |
| run_i | input | 1 | Shift and add one bit this clock |
| bit_i | input | 1 | Serial operand bit, least significant first |
| sum_o | output | WIDTH | Accumulator contents |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| ovf_o | output | 1 | Carry out of the most recent completed pass |

## Verification
The bench builds the block with the default WIDTH of 4. At this width the partial accumulator after each bit can be checked against hand-worked values, and a sweep of twelve operands walks the total through the full modulo-16 range several times. That sweep makes both overflowing and non-overflowing passes occur, including an overflow followed by a zero addend. A clear mid-pass, and a stall of several cycles inside a pass, check that the pass boundaries still fall after exactly four consumed bits.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;
  typedef struct packed {
    logic sum;
    logic cout;
  } fa_t;

  function automatic fa_t full_add(input logic a, input logic b, input logic c);
    fa_t r;
    r.sum  = a ^ b ^ c;
    r.cout = (a & b) | (c & (a ^ b));
    return r;
  endfunction
endpackage

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] par_o
);
  logic [WIDTH-1:0] q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic nxt;
    if (i == WIDTH - 1) begin : g_top
      assign nxt = ser_i;
    end else begin : g_mid
      assign nxt = q[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q[i] <= 1'b0;
      else if (clr_i)   q[i] <= 1'b0;
      else if (shift_i) q[i] <= nxt;
    end
  end

  assign par_o = q;

  assert_msb_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clr_i) |=> (par_o[WIDTH-1] == $past(ser_i)));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !clr_i) |=> $stable(par_o));
endmodule

// File: rtl/sa_carry_cell.sv
module sa_carry_cell
  import serial_add_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic last_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic cout_o,
  output logic carry_o
);
  fa_t  fa;
  logic c_q;

  assign fa = full_add(a_i, b_i, c_q);

  // carry restarts from zero after the top bit of a pass
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   c_q <= 1'b0;
    else if (clr_i) c_q <= 1'b0;
    else if (en_i) c_q <= last_i ? 1'b0 : fa.cout;
  end

  assign sum_o   = fa.sum;
  assign cout_o  = fa.cout;
  assign carry_o = c_q;
endmodule

// File: rtl/sa_pass_ctr.sv
module sa_pass_ctr #(
  parameter int unsigned WIDTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o,
  output logic done_o
);
  localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= en_i && last_o;
      if (en_i) cnt_q <= last_o ? '0 : cnt_q + ONE;
    end
  end

  assign done_o = done_q;

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(en_i) && !$past(clr_i)));
endmodule

// File: rtl/serial_accum_adder.sv
module serial_accum_adder #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             done_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] a_q, b_q;
  logic sum_bit, cout, carry_q, last, ovf_q;

  sa_shift_reg #(.WIDTH(WIDTH)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear_i), .shift_i(run_i),
    .ser_i(sum_bit), .par_o(a_q)
  );

  sa_shift_reg #(.WIDTH(WIDTH)) u_opnd (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear_i), .shift_i(run_i),
    .ser_i(bit_i), .par_o(b_q)
  );

  sa_carry_cell u_fa (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear_i), .en_i(run_i),
    .last_i(last), .a_i(a_q[0]), .b_i(b_q[0]),
    .sum_o(sum_bit), .cout_o(cout), .carry_o(carry_q)
  );

  sa_pass_ctr #(.WIDTH(WIDTH)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear_i), .en_i(run_i),
    .last_o(last), .done_o(done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ovf_q <= 1'b0;
    else if (clear_i)         ovf_q <= 1'b0;
    else if (run_i && last)   ovf_q <= cout;
  end

  assign sum_o = a_q;
  assign ovf_o = ovf_q;

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (a_q == '0 && b_q == '0 && !carry_q && !done_o && !ovf_o));
  assert_carry_fresh_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !carry_q);
  assert_ovf_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ovf_o) |-> (done_o || $past(clear_i)));
endmodule

// File: tb/tb_serial_accum_adder.sv
module tb_serial_accum_adder;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, run = 1'b0, bit_in = 1'b0;
  logic [W-1:0] sum;
  logic done, ovf;
  int total = 0, bad = 0;
  logic [W-1:0] m_a = '0, m_b = '0;
  logic m_ovf = 1'b0;

  always #5 clk = ~clk;

  serial_accum_adder #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .run_i(run),
    .bit_i(bit_in), .sum_o(sum), .done_o(done), .ovf_o(ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one full pass; checks sum, done and overflow against the model
  task automatic do_pass(input logic [W-1:0] op, input string req);
    logic [W:0] full;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      if (i > 0) chk("R4", "done mid-pass", int'(done), 0);
      run = 1'b1; bit_in = op[i];
    end
    @(negedge clk);
    run = 1'b0; bit_in = 1'b0;
    full = {1'b0, m_a} + {1'b0, m_b};
    m_a = full[W-1:0]; m_ovf = full[W]; m_b = op;
    chk(req, "sum", int'(sum), int'(m_a));
    chk("R5", "ovf", int'(ovf), int'(m_ovf));
    chk("R4", "done at pass end", int'(done), 1);
    @(negedge clk);
    chk("R4", "done after pulse", int'(done), 0);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1; run = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    clear = 1'b0; run = 1'b0; bit_in = 1'b0;
    m_a = '0; m_b = '0; m_ovf = 1'b0;
    chk("R8", "sum after clear", int'(sum), 0);
    chk("R8", "done after clear", int'(done), 0);
    chk("R8", "ovf after clear", int'(ovf), 0);
  endtask

  task automatic t_reset();
    chk("R1", "sum in reset", int'(sum), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "ovf in reset", int'(ovf), 0);
  endtask

  task automatic t_example();
    logic [W-1:0] trace [W] = '{4'b0011, 4'b1001, 4'b0100, 4'b1010};
    logic [W-1:0] op3 = 4'b0000;
    do_clear();
    do_pass(4'b0111, "R2");
    do_pass(4'b0011, "R3");
    chk("R3", "0+0111", int'(sum), 7);
    // third pass, bit-by-bit trace of 0111 + 0011
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      if (i > 0) chk("R9", $sformatf("partial bit %0d", i), int'(sum), int'(trace[i-1]));
      run = 1'b1; bit_in = op3[i];
    end
    @(negedge clk);
    run = 1'b0;
    chk("R9", "partial bit 4", int'(sum), int'(trace[W-1]));
    chk("R3", "0111+0011", int'(sum), 10);
    chk("R4", "done example", int'(done), 1);
    m_a = 4'b1010; m_b = op3; m_ovf = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_overflow();
    do_pass(4'b1000, "R3");   // adds 0000
    do_pass(4'b0000, "R5");   // adds 1000 -> 1010+1000 overflows
    chk("R5", "ovf raised", int'(ovf), 1);
    chk("R5", "wrapped sum", int'(sum), 2);
    repeat (2) @(negedge clk);
    chk("R5", "ovf held", int'(ovf), 1);
    do_pass(4'b0000, "R6");   // adds 0000, no leaked carry
    chk("R6", "no carry leak", int'(sum), 2);
  endtask

  task automatic t_stall();
    logic [W-1:0] op = 4'b0110;
    logic [W-1:0] held;
    logic [W:0] full;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      run = 1'b1; bit_in = op[i];
      if (i == 2) begin
        @(negedge clk);
        run = 1'b0;
        held = sum;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk("R7", "sum stable in stall", int'(sum), int'(held));
          chk("R7", "done low in stall", int'(done), 0);
        end
      end
    end
    @(negedge clk);
    run = 1'b0;
    full = {1'b0, m_a} + {1'b0, m_b};
    m_a = full[W-1:0]; m_ovf = full[W]; m_b = op;
    chk("R7", "sum after stall", int'(sum), int'(m_a));
    chk("R7", "done after stall", int'(done), 1);
    @(negedge clk);
  endtask

  task automatic t_clear_mid();
    do_pass(4'b1111, "R3");
    do_pass(4'b1111, "R3");
    do_pass(4'b0000, "R5");
    chk("R5", "ovf before clear", int'(ovf), 1);
    // two bits into a pass, then clear together with run
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      run = 1'b1; bit_in = 1'b1;
    end
    do_clear();
    do_pass(4'b0101, "R8");   // adds cleared operand
    chk("R8", "sum from cleared B", int'(sum), 0);
    do_pass(4'b0000, "R8");
    chk("R8", "sum after restart", int'(sum), 5);
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 12; k++) do_pass(4'((k * 5 + 3) & 15), "R3");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_example();
    t_overflow();
    t_stall();
    t_clear_mid();
    t_sweep();
    summary();
  end
endmodule